// File: doc/BRIEF.md
# Bus Command Mailbox Receiver

The block accepts commands that other agents on the system bus write to this module and hands them to the local processor. Each incoming bus write that reaches this slot passes an address filter. The filter looks only at the three most significant bits of the low address byte, and a command is any write whose bits 7:5 are all zero. The rest of the address does not affect the match. On a match the 32-bit write data is latched into a read-only command register. The second address byte and a side-band data byte (bus data byte 6) are latched into fields of a read-only status word, and an interrupt goes to the processor.

The processor services the interrupt by reading the status word and then the command register. The command read acknowledges the command. A small controller with three states tracks delivery. EMPTY means no command is waiting. FULL means one unread command is held. OVERRUN means at least one command was overwritten before it was read. The transitions are:
- ACCEPT: EMPTY to FULL on a match.
- OVERWRITE: FULL to OVERRUN on a match with no read.
- DRAIN: FULL or OVERRUN to EMPTY on a read with no match.
- REFILL: any state to FULL when a match and a read fall in the same cycle.
- HOLD: no change in all other cases.

Top module: `cmd_mailbox`

## Requirements
- R1: A write (`bus_wr_valid`=1) whose `bus_addr[7:5]` equals 3'b000 is accepted, whatever the values of `bus_addr[4:0]` and `bus_addr[31:16]`.
- R2: A write whose `bus_addr[7:5]` is not 3'b000 is ignored: `cmd_reg`, `stat_reg` and `irq` keep their values.
- R3: After an accepted write, `cmd_reg` shows the written `bus_data` from the next clock cycle on.
- R4: After an accepted write, `stat_reg[15:8]` shows that write's `bus_addr[15:8]` from the next cycle on.
- R5: After an accepted write, `stat_reg[23:16]` shows that write's `bus_byte6` from the next cycle on.
- R6: `irq` rises in the cycle after an accepted write and stays high until a cycle with `cpu_rd_cmd`=1 and no accepted write. It is low from the next cycle on. `stat_reg[1]` (pending) always equals `irq`.
- R7: An accepted write while a command is pending and unread overwrites the held data and sets the sticky overrun flag `stat_reg[0]`. A command read with no accepted write clears the flag.
- R8: `stat_reg[27:24]` follows the `slot_id` input in the same cycle, and `stat_reg[31:28]` and `stat_reg[7:2]` read as zero.
- R9: When an accepted write and a command read fall in the same cycle, the new command wins. `irq` stays high, `cmd_reg` takes the new data, and the overrun flag is cleared.
- R10: Reset (`rst_n`=0) clears `cmd_reg`, the captured status fields, the overrun flag and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_valid | input | 1 | A bus write to this slot is present this cycle |
| bus_addr | input | 32 | Address of the bus write |
| bus_data | input | 32 | Data word of the bus write |
| bus_byte6 | input | 8 | Side-band data byte 6 of the bus write |
| slot_id | input | 4 | Backplane slot number, shown in the status word |
| cpu_rd_cmd | input | 1 | Processor reads the command register this cycle |
| cmd_reg | output | 32 | Latest command data word |
| stat_reg | output | 32 | Status word: slot, byte 6, address byte, pending, overrun |
| irq | output | 1 | Command interrupt to the processor |

## Verification
The processor's command read can land in the same cycle as a fresh matching bus write. The bench provokes this twice. Once the overrun flag is set and the old command is unread. Once the mailbox holds a plain pending command and the write is a second one. In both cases it expects the REFILL outcome: the new data, address byte and byte 6 visible one cycle later, `irq` still high, and overrun clear. It then confirms that a following read alone drops `irq`.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_FULL     = 2'd1,
        ST_OVERRUN  = 2'd2
    } mbox_state_e;

endpackage

// File: rtl/mbox_filter.sv
module mbox_filter #(
    parameter int MATCH_BITS = 3,
    parameter logic [MATCH_BITS-1:0] MATCH_VAL = '0
) (
    input  logic                  wr_valid,
    input  logic [MATCH_BITS-1:0] addr_top,
    output logic                  hit
);
    always_comb begin
        hit = wr_valid && (addr_top == MATCH_VAL);
    end
endmodule

// File: rtl/mbox_capture.sv
module mbox_capture #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [DATA_W-1:0] data_in,
    input  logic [BYTE_W-1:0] abyte_in,
    input  logic [BYTE_W-1:0] side_in,
    output logic [DATA_W-1:0] data_q,
    output logic [BYTE_W-1:0] abyte_q,
    output logic [BYTE_W-1:0] side_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            abyte_q <= '0;
            side_q  <= '0;
        end else if (hit) begin
            data_q  <= data_in;
            abyte_q <= abyte_in;
            side_q  <= side_in;
        end
    end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd,
    output logic pending,
    output logic overrun
);
    mbox_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (hit) state_d = ST_FULL;                      // ACCEPT / REFILL
            end
            ST_FULL: begin
                if (hit && rd)       state_d = ST_FULL;          // REFILL
                else if (hit)        state_d = ST_OVERRUN;       // OVERWRITE
                else if (rd)         state_d = ST_EMPTY;         // DRAIN
            end
            ST_OVERRUN: begin
                if (hit && rd)       state_d = ST_FULL;          // REFILL
                else if (rd)         state_d = ST_EMPTY;         // DRAIN
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        pending = (state_q != ST_EMPTY);
        overrun = (state_q == ST_OVERRUN);
    end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int SLOT_W     = 4,
    parameter int MATCH_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [7:0]        bus_byte6,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic              cpu_rd_cmd,
    output logic [DATA_W-1:0] cmd_reg,
    output logic [31:0]       stat_reg,
    output logic              irq
);
    localparam int BYTE_W    = 8;
    localparam int TOP_HI    = BYTE_W - 1;
    localparam int TOP_LO    = BYTE_W - MATCH_BITS;
    localparam int AB_LO     = BYTE_W;
    localparam int AB_HI     = 2 * BYTE_W - 1;
    localparam int STAT_PAD  = 32 - SLOT_W - 3 * BYTE_W;

    logic              hit;
    logic [BYTE_W-1:0] abyte_q;
    logic [BYTE_W-1:0] side_q;
    logic              pending;
    logic              overrun;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^{bus_addr[ADDR_W-1:AB_HI+1], bus_addr[TOP_LO-1:0]};

    mbox_filter #(
        .MATCH_BITS (MATCH_BITS),
        .MATCH_VAL  ('0)
    ) u_filter (
        .wr_valid (bus_wr_valid),
        .addr_top (bus_addr[TOP_HI:TOP_LO]),
        .hit      (hit)
    );

    mbox_capture #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .data_in  (bus_data),
        .abyte_in (bus_addr[AB_HI:AB_LO]),
        .side_in  (bus_byte6),
        .data_q   (cmd_reg),
        .abyte_q  (abyte_q),
        .side_q   (side_q)
    );

    mbox_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .rd      (cpu_rd_cmd),
        .pending (pending),
        .overrun (overrun)
    );

    always_comb begin
        stat_reg = {{STAT_PAD{1'b0}}, slot_id, side_q, abyte_q, 6'b0, pending, overrun};
        irq      = pending;
    end
endmodule

// File: rtl/cmd_mailbox_checker.sv
module cmd_mailbox_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic [SLOT_W-1:0] slot_id,
    input logic              cpu_rd_cmd,
    input logic [DATA_W-1:0] cmd_reg,
    input logic [31:0]       stat_reg,
    input logic              irq
);
    logic cmd_wr;
    assign cmd_wr = bus_wr_valid && (bus_addr[7:5] == 3'b000);

    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> cmd_reg == $past(bus_data));

    p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(cmd_reg));

    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> irq);

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_cmd && !cmd_wr) |=> (!irq && !stat_reg[0]));

    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cmd_wr && !cpu_rd_cmd) |=> stat_reg[0]);

    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cpu_rd_cmd) |=> (irq && !stat_reg[0]));

    always_comb begin
        if (rst_n) begin
            p_slot_r8: assert (stat_reg[27:24] == slot_id);
            p_pending_r6: assert (stat_reg[1] == irq);
        end
    end
endmodule

bind cmd_mailbox cmd_mailbox_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr_valid (bus_wr_valid),
    .bus_addr     (bus_addr),
    .bus_data     (bus_data),
    .slot_id      (slot_id),
    .cpu_rd_cmd   (cpu_rd_cmd),
    .cmd_reg      (cmd_reg),
    .stat_reg     (stat_reg),
    .irq          (irq)
);

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [7:0]  bus_byte6 = '0;
    logic [3:0]  slot_id = 4'h9;
    logic        cpu_rd_cmd = 1'b0;
    logic [31:0] cmd_reg;
    logic [31:0] stat_reg;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cmd_mailbox u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_valid (bus_wr_valid),
        .bus_addr     (bus_addr),
        .bus_data     (bus_data),
        .bus_byte6    (bus_byte6),
        .slot_id      (slot_id),
        .cpu_rd_cmd   (cpu_rd_cmd),
        .cmd_reg      (cmd_reg),
        .stat_reg     (stat_reg),
        .irq          (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] data;
        logic [7:0]  b6;
        logic        rd;
        logic [31:0] ecmd;
        logic        eirq;
        logic        eovr;
        logic [7:0]  eab;
        logic [7:0]  eb6;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h0000_3A05, 32'h1111_1111, 8'hA1, 1'b0, 32'h1111_1111, 1'b1, 1'b0, 8'h3A, 8'hA1}, // R1 accept
        '{1'b0, 32'h0000_0000, 32'h0000_0000, 8'h00, 1'b1, 32'h1111_1111, 1'b0, 1'b0, 8'h3A, 8'hA1}, // R6 drain
        '{1'b1, 32'h0000_4420, 32'h2222_2222, 8'hEE, 1'b0, 32'h1111_1111, 1'b0, 1'b0, 8'h3A, 8'hA1}, // R2 top=001
        '{1'b1, 32'hFFFF_551F, 32'h3333_3333, 8'hB2, 1'b0, 32'h3333_3333, 1'b1, 1'b0, 8'h55, 8'hB2}, // R1 low bits set
        '{1'b1, 32'h0000_66E0, 32'h4444_4444, 8'hEE, 1'b0, 32'h3333_3333, 1'b1, 1'b0, 8'h55, 8'hB2}, // R2 top=111
        '{1'b1, 32'h1234_7700, 32'h5555_5555, 8'hC3, 1'b0, 32'h5555_5555, 1'b1, 1'b1, 8'h77, 8'hC3}, // R7 overwrite
        '{1'b1, 32'h0000_8801, 32'h6666_6666, 8'hD4, 1'b1, 32'h6666_6666, 1'b1, 1'b0, 8'h88, 8'hD4}, // R9 collide
        '{1'b0, 32'h0000_0000, 32'h0000_0000, 8'h00, 1'b1, 32'h6666_6666, 1'b0, 1'b0, 8'h88, 8'hD4}  // R6 drain
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [31:0] a, input logic [31:0] d,
                         input logic [7:0] b, input logic rd);
        bus_wr_valid = wr;
        bus_addr     = a;
        bus_data     = d;
        bus_byte6    = b;
        cpu_rd_cmd   = rd;
        @(negedge clk);
        bus_wr_valid = 1'b0;
        cpu_rd_cmd   = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 cmd", cmd_reg, 32'h0);
        chk("R10 stat", stat_reg, 32'h0900_0000);
        chk("R10 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].b6, VEC[i].rd);
            chk("R3 cmd", cmd_reg, VEC[i].ecmd);
            chk("R6 irq", {31'b0, irq}, {31'b0, VEC[i].eirq});
            chk("R6 pending bit", {31'b0, stat_reg[1]}, {31'b0, VEC[i].eirq});
            chk("R7 overrun", {31'b0, stat_reg[0]}, {31'b0, VEC[i].eovr});
            chk("R4 addr byte", {24'b0, stat_reg[15:8]}, {24'b0, VEC[i].eab});
            chk("R5 byte6", {24'b0, stat_reg[23:16]}, {24'b0, VEC[i].eb6});
        end

        // R8: slot pass-through and zero fields
        slot_id = 4'h5;
        #1;
        chk("R8 slot", {28'b0, stat_reg[27:24]}, 32'h5);
        chk("R8 zero fields", {24'b0, stat_reg[31:28], stat_reg[7:4]}, 32'h0);
        chk("R8 zero low", {30'b0, stat_reg[3:2]}, 32'h0);

        // R9 from plain pending state: accept, then second write with read
        drive(1'b1, 32'h0000_1200, 32'hAAAA_0001, 8'h11, 1'b0);
        drive(1'b1, 32'h0000_3410, 32'hAAAA_0002, 8'h22, 1'b1);
        chk("R9 cmd", cmd_reg, 32'hAAAA_0002);
        chk("R9 irq", {31'b0, irq}, 32'h1);
        chk("R9 overrun", {31'b0, stat_reg[0]}, 32'h0);
        chk("R9 abyte", {24'b0, stat_reg[15:8]}, 32'h34);

        // R7: overrun survives status-only activity and idle cycles
        drive(1'b1, 32'h0000_5600, 32'hAAAA_0003, 8'h33, 1'b0);
        drive(1'b0, 32'h0, 32'h0, 8'h0, 1'b0);
        chk("R7 sticky", {31'b0, stat_reg[0]}, 32'h1);
        drive(1'b0, 32'h0, 32'h0, 8'h0, 1'b1);
        chk("R7 clear", {30'b0, stat_reg[1:0]}, 32'h0);

        // R2: non-matching write with read idle leaves everything
        drive(1'b1, 32'h0000_99A0, 32'hBBBB_BBBB, 8'h77, 1'b0);
        chk("R2 cmd held", cmd_reg, 32'hAAAA_0003);
        chk("R2 irq low", {31'b0, irq}, 32'h0);
        chk("R2 byte6 held", {24'b0, stat_reg[23:16]}, 32'h33);

        // R10: reset while pending
        drive(1'b1, 32'h0000_7700, 32'hCCCC_CCCC, 8'h44, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 cmd after", cmd_reg, 32'h0);
        chk("R10 stat after", stat_reg, 32'h0500_0000);
        chk("R10 irq after", {31'b0, irq}, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule